// File: doc/BRIEF.md
# Guarded Mass-Erase Test Data Register

This block sits behind a JTAG test access port and gives a debugger one way to wipe the whole on-chip flash, plus a way to see when the wipe has finished. It contains the TAP state machine, an 8-bit instruction register and three data registers: a 1-bit bypass cell, a 32-bit identification register, and a 16-bit erase control register. The control register holds a request bit and a write-enable latch. A shifted word changes the request only when the word also carries its enable bit. A separate acknowledge bit tells software that an erase is in progress.

The request bit crosses into the system clock domain through a two-flop synchronizer. A rising edge there starts a stand-in flash controller, which stays busy for a programmable number of system cycles. The controller also times how long the request stays high. Releasing it too soon aborts the erase and raises an early-release flag. Holding it too long raises a late-release flag, and the held request never starts a second erase. The acknowledge bit crosses back to TCK through a second two-flop synchronizer and is loaded into the register at every capture, so each scan shows live state.

Top module: `erase_guard_top`

## Requirements
- R1: After TCK-domain reset the instruction register selects the identification register. A 32-bit data scan returns 0x16B4801D, LSB first on tdo.
- R2: Instruction 0xFF (and any code other than 0x02 and 0x09) selects a 1-bit bypass cell that captures 0. Shifting 8 bits of 0xA5 therefore returns 0x4A.
- R3: With instruction 0x09 selected, an Update-DR whose shifted bit 15 is 0 leaves the request bit (bit 0) unchanged. A word of 0x0001 written this way starts no erase.
- R4: An Update-DR with bit 15 set loads the request from bit 0 and sets the write-enable latch. Writing 0x8001 makes the next capture show bits 15 and 0 set.
- R5: A rising edge of the synchronized request sets the acknowledge bit and starts one erase. flash_busy then stays high for exactly erase_len system cycles, and the acknowledge bit returns to 0 only when that erase ends or is aborted.
- R6: The write-enable latch clears on any Update-DR of register 0x09 whose bit 15 is 0. Writing 0x8000 and then 0x0000 leaves capture bit 15 at 0.
- R7: If the request falls after fewer than MIN_HOLD system cycles high, err_early is set, the erase is aborted (flash_busy low) and the acknowledge bit clears.
- R8: If the request stays high for MAX_HOLD system cycles, err_late is set. A request that stays high never starts a second erase, and the acknowledge bit reads 0 once the erase is done.
- R9: A release inside the window raises neither flag. Each new rising edge of the request clears both flags.
- R10: Capture-DR of register 0x09 loads bit 15 = write-enable latch, bit 1 = synchronized acknowledge, bit 0 = request, and all other bits 0.
- R11: Five TCK cycles with TMS high put the TAP in Test-Logic-Reset, which reselects the identification register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, LSB of the active shift register |
| sys_clk | input | 1 | System clock of the flash controller |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| erase_len | input | LEN_W | Erase duration in system cycles (0 acts as 1) |
| flash_busy | output | 1 | Erase in progress in the flash stand-in |
| err_early | output | 1 | Request released before MIN_HOLD cycles |
| err_late | output | 1 | Request held for MAX_HOLD cycles |

## Verification
Assertions check the cycle-level rules on every clock: a guarded update leaves the request alone and drops the enable latch, a request edge raises the acknowledge, early and late releases raise their flags, an in-window release raises no early flag, no start arrives while the controller is busy, and five TMS-high clocks reach reset. Only the bench scenarios can show the end-to-end sequences. These include the exact erase length seen at flash_busy, the live acknowledge read back through a scan after two clock crossings, the absence of a retrigger while a request is held, and the clearing of flags by the next request.

// File: rtl/erase_tap_pkg.sv
package erase_tap_pkg;

    localparam int IR_W     = 8;
    localparam int ID_W     = 32;
    localparam int CTRL_W   = 16;
    localparam int BIT_REQ  = 0;
    localparam int BIT_ACK  = 1;
    localparam int BIT_WEN  = 15;

    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h02;
    localparam logic [IR_W-1:0] OP_ERASE   = 8'h09;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_ERASE
    } dr_sel_e;

    typedef struct packed {
        logic wen;
        logic req;
    } ctrl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            S_RESET:  return m ? S_RESET  : S_IDLE;
            S_IDLE:   return m ? S_SEL_DR : S_IDLE;
            S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: return m ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  return m ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: return m ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: return m ? S_SEL_DR : S_IDLE;
            S_SEL_IR: return m ? S_RESET  : S_CAP_IR;
            S_CAP_IR: return m ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  return m ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: return m ? S_UPD_IR : S_SH_IR;
            default:  return m ? S_SEL_DR : S_IDLE;
        endcase
    endfunction

    function automatic dr_sel_e decode_ir(logic [IR_W-1:0] op);
        if (op == OP_IDCODE)
            return DR_IDENT;
        else if (op == OP_ERASE)
            return DR_ERASE;
        else
            return DR_BYPASS;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_status(ctrl_t c, logic ack);
        logic [CTRL_W-1:0] w;
        w          = '0;
        w[BIT_WEN] = c.wen;
        w[BIT_ACK] = ack;
        w[BIT_REQ] = c.req;
        return w;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
    import erase_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= S_RESET;
        else     state <= tap_next(state, tms);
    end

    // R11: five TMS-high clocks always end in Test-Logic-Reset
    a_r11_tms_reset: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == S_RESET);
endmodule

// File: rtl/jtag_regs.sv
module jtag_regs
    import erase_tap_pkg::*;
#(
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h16B4801D
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    input  logic       ack_tck,
    output logic       tdo,
    output logic       req
);
    logic [IR_W-1:0] ir_q;
    logic [IR_W-1:0] ir_sh;
    logic [ID_W-1:0] dr_sh;
    ctrl_t           ctrl_q;
    dr_sel_e         sel;

    assign sel = decode_ir(ir_q);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_q  <= OP_IDCODE;
            ir_sh <= '0;
        end else begin
            case (state)
                S_RESET:  ir_q  <= OP_IDCODE;
                S_CAP_IR: ir_sh <= IR_CAPTURE;
                S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                S_UPD_IR: ir_q  <= ir_sh;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            dr_sh <= '0;
        end else if (state == S_CAP_DR) begin
            case (sel)
                DR_IDENT: dr_sh <= IDCODE_VAL;
                DR_ERASE: dr_sh <= {{(ID_W-CTRL_W){1'b0}}, pack_status(ctrl_q, ack_tck)};
                default:  dr_sh <= '0;
            endcase
        end else if (state == S_SH_DR) begin
            case (sel)
                DR_IDENT: dr_sh <= {tdi, dr_sh[ID_W-1:1]};
                DR_ERASE: dr_sh[CTRL_W-1:0] <= {tdi, dr_sh[CTRL_W-1:1]};
                default:  dr_sh[0] <= tdi;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (state == S_UPD_DR && sel == DR_ERASE) begin
            if (dr_sh[BIT_WEN]) begin
                ctrl_q.wen <= 1'b1;
                ctrl_q.req <= dr_sh[BIT_REQ];
            end else begin
                ctrl_q.wen <= 1'b0;
            end
        end
    end

    assign req = ctrl_q.req;
    assign tdo = (state == S_SH_IR) ? ir_sh[0] : dr_sh[0];

    // R3: an unguarded update leaves the request alone
    a_r3_guarded_req: assert property (@(posedge tck) disable iff (rst)
        (state == S_UPD_DR && sel == DR_ERASE && !dr_sh[BIT_WEN])
        |=> req == $past(req));

    // R4: a guarded update takes bit 0 as the new request
    a_r4_enabled_load: assert property (@(posedge tck) disable iff (rst)
        (state == S_UPD_DR && sel == DR_ERASE && dr_sh[BIT_WEN])
        |=> req == $past(dr_sh[BIT_REQ]));

    // R6: the enable latch drops on an unguarded update
    a_r6_wen_drops: assert property (@(posedge tck) disable iff (rst)
        (state == S_UPD_DR && sel == DR_ERASE && !dr_sh[BIT_WEN])
        |=> !ctrl_q.wen);
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl #(
    parameter int MIN_HOLD = 200,
    parameter int MAX_HOLD = 1000,
    parameter int CNT_W    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic done,
    output logic start,
    output logic abort,
    output logic ack,
    output logic err_early,
    output logic err_late
);
    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_HOLD);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_HOLD);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(MAX_HOLD - 1);

    logic             req_d;
    logic             holding;
    logic [CNT_W-1:0] cnt;
    logic             rise;
    logic             fall;

    assign rise = req_s & ~req_d;
    assign fall = ~req_s & req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d     <= 1'b0;
            holding   <= 1'b0;
            cnt       <= '0;
            start     <= 1'b0;
            abort     <= 1'b0;
            ack       <= 1'b0;
            err_early <= 1'b0;
            err_late  <= 1'b0;
        end else begin
            req_d <= req_s;
            start <= 1'b0;
            abort <= 1'b0;
            if (rise) begin
                holding   <= 1'b1;
                cnt       <= CNT_W'(1);
                err_early <= 1'b0;
                err_late  <= 1'b0;
                ack       <= 1'b1;
                start     <= ~ack;
            end else begin
                if (holding && req_s) begin
                    if (cnt >= LAST_C) begin
                        cnt      <= MAX_C;
                        holding  <= 1'b0;
                        err_late <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (holding && fall) begin
                    holding <= 1'b0;
                    if (cnt < MIN_C) begin
                        err_early <= 1'b1;
                        abort     <= 1'b1;
                        ack       <= 1'b0;
                    end
                end
                if (done) ack <= 1'b0;
            end
        end
    end

    // R5: a request edge raises the acknowledge
    a_r5_ack_on_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> ack);

    // R7: short hold flags and drops the acknowledge
    a_r7_early_abort: assert property (@(posedge clk) disable iff (rst)
        (holding && fall && cnt < MIN_C) |=> (err_early && !ack && abort));

    // R8: reaching the upper limit flags a late release
    a_r8_late_flag: assert property (@(posedge clk) disable iff (rst)
        (holding && req_s && !rise && cnt >= LAST_C) |=> err_late);

    // R9: an in-window release leaves the early flag low
    a_r9_window_ok: assert property (@(posedge clk) disable iff (rst)
        (holding && fall && cnt >= MIN_C) |=> !err_early);
endmodule

// File: rtl/flash_stub.sv
module flash_stub #(
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start) begin
                busy   <= 1'b1;
                remain <= (len == '0) ? LEN_W'(1) : len;
            end else if (busy) begin
                if (remain <= LEN_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    // R8: the controller never receives a start while an erase runs
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/erase_guard_top.sv
module erase_guard_top
    import erase_tap_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL  = 32'h16B4801D,
    parameter int          MIN_HOLD    = 200,
    parameter int          MAX_HOLD    = 1000,
    parameter int          LEN_W       = 20,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             tck,
    input  logic             tck_rst,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    input  logic             sys_clk,
    input  logic             sys_rst,
    input  logic [LEN_W-1:0] erase_len,
    output logic             flash_busy,
    output logic             err_early,
    output logic             err_late
);
    localparam int CNT_W = $clog2(MAX_HOLD + 1);

    tap_state_e state;
    logic       req_tck;
    logic       req_sys;
    logic       ack_sys;
    logic       ack_tck;
    logic       start;
    logic       abort;
    logic       done;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (tck_rst),
        .tms   (tms),
        .state (state)
    );

    jtag_regs #(.IDCODE_VAL(IDCODE_VAL)) u_regs (
        .tck     (tck),
        .rst     (tck_rst),
        .state   (state),
        .tdi     (tdi),
        .ack_tck (ack_tck),
        .tdo     (tdo),
        .req     (req_tck)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (req_tck),
        .q   (req_sys)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (tck),
        .rst (tck_rst),
        .d   (ack_sys),
        .q   (ack_tck)
    );

    erase_ctrl #(
        .MIN_HOLD (MIN_HOLD),
        .MAX_HOLD (MAX_HOLD),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .req_s     (req_sys),
        .done      (done),
        .start     (start),
        .abort     (abort),
        .ack       (ack_sys),
        .err_early (err_early),
        .err_late  (err_late)
    );

    flash_stub #(.LEN_W(LEN_W)) u_flash (
        .clk   (sys_clk),
        .rst   (sys_rst),
        .start (start),
        .abort (abort),
        .len   (erase_len),
        .busy  (flash_busy),
        .done  (done)
    );
endmodule

// File: tb/tb_erase_guard_top.sv
module tb_erase_guard_top;
    localparam logic [31:0] ID = 32'h16B4801D;

    logic        tck = 1'b0;
    logic        sys_clk = 1'b0;
    logic        tck_rst = 1'b1;
    logic        sys_rst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [19:0] erase_len = 20'd1500;
    logic        tdo;
    logic        flash_busy;
    logic        err_early;
    logic        err_late;

    always #50 tck = ~tck;
    always #10 sys_clk = ~sys_clk;

    erase_guard_top dut (
        .tck        (tck),
        .tck_rst    (tck_rst),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .sys_clk    (sys_clk),
        .sys_rst    (sys_rst),
        .erase_len  (erase_len),
        .flash_busy (flash_busy),
        .err_early  (err_early),
        .err_late   (err_late)
    );

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;

    exp_t        dr_q[$];
    int          dur_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] obs;
    event        obs_ev;
    bit          finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
    endtask

    task automatic idle(input int n);
        repeat (n) tick(1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [7:0] v);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge tck);
            tms = (i == 7);
            tdi = v[i];
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    // driver: pushes the expected capture, then shifts
    task automatic scan_dr(input logic [31:0] din, input int n,
                           input string tag, input logic [31:0] exp);
        logic [31:0] w;
        dr_q.push_back('{tag, exp});
        w = '0;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            w[i] = tdo;
            tms  = (i == n - 1);
            tdi  = din[i];
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        obs = w;
        -> obs_ev;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: scan results against the expectation queue
    initial begin
        forever begin
            exp_t e;
            @(obs_ev);
            if (dr_q.size() == 0) begin
                chk("scan without expectation", obs, 32'hx);
            end else begin
                e = dr_q.pop_front();
                chk(e.tag, obs, e.val);
            end
        end
    end

    // monitor: erase length at flash_busy against the duration queue
    initial begin
        int  run;
        bit  was;
        run = 0;
        was = 1'b0;
        forever begin
            @(negedge sys_clk);
            if (!sys_rst) begin
                if (flash_busy) begin
                    if (!was) begin
                        run = 0;
                        if (dur_q.size() == 0) chk("R8 unexpected erase start", 1, 0);
                    end
                    run++;
                end else if (was && dur_q.size() != 0) begin
                    int d;
                    d = dur_q.pop_front();
                    if (d < 0) chk("R7 aborted erase shorter than erase_len",
                                   (run < int'(erase_len)), 1);
                    else       chk("R5 erase length", run, d);
                end
                was = flash_busy;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge tck);
        tck_rst = 1'b0;
        sys_rst = 1'b0;
        tick(1'b0, 1'b0);
        idle(2);

        // R1: reset state and identification
        chk("R1 flash_busy after reset", flash_busy, 0);
        chk("R1 err_early after reset", err_early, 0);
        chk("R1 err_late after reset", err_late, 0);
        scan_dr(32'h0, 32, "R1 identification after reset", ID);

        // R2: bypass cell
        scan_ir(8'hFF);
        scan_dr(32'hA5, 8, "R2 bypass one-bit delay", 32'h4A);

        // R3: unguarded write does nothing
        scan_ir(8'h09);
        scan_dr(32'h0, 16, "R10 idle capture", 32'h0000);
        scan_dr(32'h0001, 16, "R3 capture before unguarded write", 32'h0000);
        idle(20);
        chk("R3 no erase from unguarded write", flash_busy, 0);
        scan_dr(32'h0, 16, "R3 request still clear", 32'h0000);

        // R4 R5 R6 R9 R10: normal in-window erase
        erase_len = 20'd1500;
        dur_q.push_back(1500);
        scan_dr(32'h8001, 16, "R4 capture before enabled write", 32'h0000);
        idle(10);
        chk("R5 busy after request edge", flash_busy, 1);
        scan_dr(32'h0, 16, "R4 R10 request, enable and ack", 32'h8003);
        idle(20);
        scan_dr(32'h8000, 16, "R6 enable dropped by read", 32'h0003);
        scan_dr(32'h0, 16, "R6 enable latched after 0x8000", 32'h8002);
        scan_dr(32'h0, 16, "R6 enable cleared by 0x0000", 32'h0002);
        scan_dr(32'h0001, 16, "R3 capture before unguarded set", 32'h0002);
        idle(10);
        scan_dr(32'h0, 16, "R3 unguarded set ignored", 32'h0002);
        chk("R9 no early flag in window", err_early, 0);
        chk("R9 no late flag in window", err_late, 0);
        idle(320);
        scan_dr(32'h0, 16, "R5 ack returns to 0 after erase", 32'h0000);
        chk("R5 busy low after erase", flash_busy, 0);

        // R7: early release aborts
        dur_q.push_back(-1);
        scan_dr(32'h8001, 16, "R7 capture before request", 32'h0000);
        idle(3);
        scan_dr(32'h8000, 16, "R7 ack seen before early release", 32'h8003);
        idle(10);
        chk("R7 early flag", err_early, 1);
        chk("R7 erase aborted", flash_busy, 0);
        scan_dr(32'h0, 16, "R7 ack cleared by abort", 32'h8000);
        scan_dr(32'h0, 16, "R6 enable cleared by read", 32'h0000);

        // R8 R9: late release, no retrigger
        erase_len = 20'd300;
        dur_q.push_back(300);
        scan_dr(32'h8001, 16, "R8 capture before request", 32'h0000);
        idle(10);
        chk("R9 early flag cleared by new request", err_early, 0);
        idle(250);
        chk("R8 late flag", err_late, 1);
        chk("R8 no retrigger while held", flash_busy, 0);
        scan_dr(32'h0, 16, "R8 ack 0 with request held", 32'h8001);
        scan_dr(32'h8000, 16, "R8 capture before release", 32'h0001);
        idle(10);
        chk("R8 late release is not early", err_early, 0);
        scan_dr(32'h0, 16, "R8 released state", 32'h8000);

        // R11: TMS reset reselects identification
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        idle(2);
        scan_dr(32'h0, 32, "R11 identification after TMS reset", ID);

        idle(20);
        chk("R5 every expected erase observed", dur_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule